// File: doc/BRIEF.md
# Frame Store and Encode Arbiter

This controller decides when a shared external frame memory is being filled from the video side and when it is being emptied into a compression engine. The memory cannot serve a write stream and a read stream at once, so the arbiter gives the memory to exactly one of them. It opens the write phase on a start-of-frame marker and closes it on end-of-frame. It then issues a one-cycle start pulse to the encoder and waits for the encoder to acknowledge with busy before it opens the read phase. The read phase ends once a parameterised number of words (width times height) has been transferred.

After the read phase the controller either waits for the encoder to signal done, or, when the early-rearm input is high, returns at once to waiting for the next frame. A start-of-frame that arrives while the controller is handing off to the encoder, reading, or waiting for done is counted as a dropped frame on a saturating counter. An encoder that never answers the start pulse is caught by a timeout, which raises a sticky error flag and returns the controller to idle.

Top module: `frame_store_arbiter`

## Requirements
- R1: After reset, wr_en_o, rd_en_o, enc_start_o and ack_err_o are 0 and drop_cnt_o is 0.
- R2: While idle the controller ignores eof_i. A sof_i high at a clock edge in idle makes wr_en_o high from the following cycle.
- R3: wr_en_o stays high until eof_i is sampled high. On that edge wr_en_o goes low and enc_start_o goes high for exactly one cycle.
- R4: rd_en_o stays low after the start pulse until enc_busy_i is sampled high. rd_en_o is high from the cycle after that edge.
- R5: rd_en_o stays high until FRAME_W*FRAME_H edges with rd_word_i high have been seen in the read phase. It is low from the cycle after the last of them.
- R6: wr_en_o and rd_en_o are never high in the same cycle.
- R7: With early_rearm_i low, after the read phase the controller waits for enc_done_i. A sof_i during that wait does not open a write phase. After done, the next sof_i opens one.
- R8: With early_rearm_i high at the last read word, the controller is idle in the next cycle, and a sof_i there opens a write phase without any enc_done_i.
- R9: Each edge with sof_i high while waiting for busy, reading or waiting for done adds 1 to drop_cnt_o. The count saturates at 255. A sof_i during the write phase is not counted.
- R10: If enc_busy_i is not seen within ACK_TIMEOUT edges after the start pulse, ack_err_o goes high and stays high until reset, and the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_rearm_i | input | 1 | 1: skip the wait for encoder done |
| sof_i | input | 1 | Start-of-frame marker from the video side |
| eof_i | input | 1 | End-of-frame marker from the video side |
| enc_busy_i | input | 1 | Encoder has accepted the start pulse |
| enc_done_i | input | 1 | Encoder has finished the frame |
| rd_word_i | input | 1 | Memory reader moved one word this cycle |
| wr_en_o | output | 1 | Enables the memory writer |
| rd_en_o | output | 1 | Enables the memory reader |
| enc_start_o | output | 1 | One-cycle start pulse to the encoder |
| drop_cnt_o | output | 8 | Saturating count of dropped frames |
| ack_err_o | output | 1 | Sticky flag: encoder did not acknowledge |

## Verification
The hardest state to reach from the ports is saturation of the drop counter. It needs more than 255 start-of-frame markers while the memory is held away from the writer. The bench gets there by parking the controller in the done-wait phase, withholding enc_done_i, and sending a long run of sof_i pulses. Random frames vary the write length, the busy delay, the gaps between read words, the stray markers and the rearm mode. A directed case lets the acknowledge window expire by exactly one edge.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WRITE = 3'd1,
    ST_ACK   = 3'd2,
    ST_READ  = 3'd3,
    ST_DRAIN = 3'd4
  } arb_state_t;

  // words in one stored frame
  function automatic int unsigned frame_words(input int unsigned w, input int unsigned h);
    return w * h;
  endfunction

  // add one, holding at all-ones
  function automatic logic [7:0] sat_inc8(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

endpackage

// File: rtl/fsa_word_counter.sv
module fsa_word_counter #(
  parameter int unsigned WORDS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic inc,
  output logic last_o
);
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = run && inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || last_o) cnt_q <= '0;
    else if (inc)                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fsa_ack_timer.sv
module fsa_ack_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire_o
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [TW-1:0] END_V = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;

  assign expire_o = run && (cnt_q == END_V);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expire_o) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fsa_sat_counter.sv
module fsa_sat_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  output logic [7:0] value_o
);
  import fsa_pkg::*;

  logic [7:0] val_q;
  assign value_o = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   val_q <= 8'd0;
    else if (inc) val_q <= sat_inc8(val_q);
  end
endmodule

// File: rtl/frame_store_arbiter.sv
module frame_store_arbiter #(
  parameter int unsigned FRAME_W     = 16,
  parameter int unsigned FRAME_H     = 8,
  parameter int unsigned ACK_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       early_rearm_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic       enc_busy_i,
  input  logic       enc_done_i,
  input  logic       rd_word_i,
  output logic       wr_en_o,
  output logic       rd_en_o,
  output logic       enc_start_o,
  output logic [7:0] drop_cnt_o,
  output logic       ack_err_o
);
  import fsa_pkg::*;

  localparam int unsigned NWORDS = frame_words(FRAME_W, FRAME_H);

  arb_state_t state_q, state_d;
  logic start_q, err_q;

  // named internal events
  logic in_write, in_ack, in_read, in_drain;
  logic frame_open, frame_close, busy_seen, read_last, ack_expired, ack_fail, drop_event;

  assign in_write = (state_q == ST_WRITE);
  assign in_ack   = (state_q == ST_ACK);
  assign in_read  = (state_q == ST_READ);
  assign in_drain = (state_q == ST_DRAIN);

  assign frame_open  = (state_q == ST_IDLE) && sof_i;
  assign frame_close = in_write && eof_i;
  assign busy_seen   = in_ack && enc_busy_i;
  assign ack_fail    = in_ack && !enc_busy_i && ack_expired;
  assign drop_event  = sof_i && (in_ack || in_read || in_drain);

  fsa_word_counter #(.WORDS(NWORDS)) u_words (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (in_read),
    .inc    (rd_word_i),
    .last_o (read_last)
  );

  fsa_ack_timer #(.LIMIT(ACK_TIMEOUT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_ack),
    .expire_o (ack_expired)
  );

  fsa_sat_counter u_drops (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (drop_event),
    .value_o (drop_cnt_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (frame_open)  state_d = ST_WRITE;
      ST_WRITE: if (frame_close) state_d = ST_ACK;
      ST_ACK: begin
        if (busy_seen)     state_d = ST_READ;
        else if (ack_fail) state_d = ST_IDLE;
      end
      ST_READ:  if (read_last)   state_d = early_rearm_i ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (enc_done_i)  state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= frame_close;
      err_q   <= err_q | ack_fail;
    end
  end

  assign wr_en_o     = in_write;
  assign rd_en_o     = in_read;
  assign enc_start_o = start_q;
  assign ack_err_o   = err_q;
endmodule

// File: rtl/fsa_checker.sv
module fsa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sof_i,
  input logic       eof_i,
  input logic       enc_busy_i,
  input logic       wr_en_o,
  input logic       rd_en_o,
  input logic       enc_start_o,
  input logic [7:0] drop_cnt_o,
  input logic       ack_err_o
);
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_o && rd_en_o)); // R6
  AST_WRITE_OPENS_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en_o) |-> $past(sof_i)); // R2
  AST_START_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start_o |-> ($past(wr_en_o) && $past(eof_i) && !wr_en_o)); // R3
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start_o |=> !enc_start_o); // R3
  AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en_o) |-> $past(enc_busy_i)); // R4
  AST_DROP_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt_o == 8'hFF) |=> (drop_cnt_o == 8'hFF)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err_o |=> ack_err_o); // R10
endmodule

bind frame_store_arbiter fsa_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sof_i       (sof_i),
  .eof_i       (eof_i),
  .enc_busy_i  (enc_busy_i),
  .wr_en_o     (wr_en_o),
  .rd_en_o     (rd_en_o),
  .enc_start_o (enc_start_o),
  .drop_cnt_o  (drop_cnt_o),
  .ack_err_o   (ack_err_o)
);

// File: tb/sim_frame_store_arbiter.sv
`timescale 1ns/1ps
module sim_frame_store_arbiter;
  localparam int W  = 4;
  localparam int H  = 2;
  localparam int TO = 6;
  localparam int NW = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic early = 1'b0, sof = 1'b0, eof = 1'b0, busy = 1'b0, done = 1'b0, rdw = 1'b0;
  logic wr_en, rd_en, start, err;
  logic [7:0] drops;

  int n_chk = 0;
  int n_fail = 0;
  int exp_drop = 0;

  always #2.5 clk = ~clk;

  frame_store_arbiter #(.FRAME_W(W), .FRAME_H(H), .ACK_TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .early_rearm_i(early), .sof_i(sof), .eof_i(eof),
    .enc_busy_i(busy), .enc_done_i(done), .rd_word_i(rdw),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .enc_start_o(start),
    .drop_cnt_o(drops), .ack_err_o(err)
  );

  function automatic int drop_after(input int v);
    return (v >= 255) ? 255 : v + 1;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // sof marker that the controller should count as a drop
  task automatic stray_sof();
    sof = 1'b1;
    exp_drop = drop_after(exp_drop);
    step();
    sof = 1'b0;
  endtask

  // from idle through the end of the read phase
  task automatic frame_to_read_end(input string open_tag);
    int len, d, gap;
    sof = 1'b1; step(); sof = 1'b0;
    chk(open_tag, "wr_en after sof", int'(wr_en), 1);
    len = 1 + int'($urandom % 6);
    for (int i = 0; i < len; i++) begin
      sof = (($urandom % 3) == 0);   // R9: not counted in write phase
      step(); sof = 1'b0;
      chk("R3", "wr_en held", int'(wr_en), 1);
      chk("R6", "rd_en during write", int'(rd_en), 0);
    end
    eof = 1'b1; step(); eof = 1'b0;
    chk("R3", "wr_en after eof", int'(wr_en), 0);
    chk("R3", "start pulse", int'(start), 1);
    d = int'($urandom % (TO - 1));
    for (int i = 0; i < d; i++) begin
      if (($urandom % 2) == 0) stray_sof(); else step();
      chk("R4", "rd_en before busy", int'(rd_en), 0);
      chk("R3", "start one cycle", int'(start), 0);
    end
    busy = 1'b1; step();
    chk("R4", "rd_en after busy", int'(rd_en), 1);
    chk("R3", "start low", int'(start), 0);
    for (int i = 0; i < NW; i++) begin
      gap = int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        if (($urandom % 2) == 0) stray_sof(); else step();
        chk("R5", "rd_en in gap", int'(rd_en), 1);
      end
      rdw = 1'b1; step(); rdw = 1'b0;
      chk("R5", "rd_en after word", int'(rd_en), (i != NW - 1) ? 1 : 0);
      chk("R6", "wr_en during read", int'(wr_en), 0);
    end
    chk("R9", "drop count after read", int'(drops), exp_drop);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    string tag;
    bit prev_early;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1", "wr_en reset", int'(wr_en), 0);
    chk("R1", "rd_en reset", int'(rd_en), 0);
    chk("R1", "start reset", int'(start), 0);
    chk("R1", "err reset", int'(err), 0);
    chk("R1", "drops reset", int'(drops), 0);

    eof = 1'b1; step(); eof = 1'b0; step();
    chk("R2", "eof ignored in idle", int'(wr_en), 0);

    prev_early = 1'b0;
    for (int f = 0; f < 12; f++) begin
      tag = prev_early ? "R8" : "R2";
      early = (($urandom % 2) == 0);
      frame_to_read_end(tag);
      busy = 1'b0;
      if (!early) begin
        stray_sof();
        chk("R7", "no write before done", int'(wr_en), 0);
        chk("R9", "drop in done wait", int'(drops), exp_drop);
        repeat (int'($urandom % 4)) step();
        done = 1'b1; step(); done = 1'b0;
        chk("R7", "idle after done", int'(wr_en), 0);
      end else begin
        chk("R8", "idle after read", int'(wr_en), 0);
      end
      prev_early = early;
    end

    // acknowledge timeout
    early = 1'b0;
    busy = 1'b0;
    sof = 1'b1; step(); sof = 1'b0;
    eof = 1'b1; step(); eof = 1'b0;
    repeat (TO - 1) step();
    chk("R10", "err before limit", int'(err), 0);
    chk("R10", "rd_en while waiting", int'(rd_en), 0);
    step();
    chk("R10", "err at limit", int'(err), 1);
    chk("R10", "rd_en at limit", int'(rd_en), 0);
    frame_to_read_end("R10");
    chk("R10", "err sticky", int'(err), 1);
    busy = 1'b0;

    // saturation while withholding done
    for (int i = 0; i < 300; i++) stray_sof();
    chk("R9", "drop saturates", int'(drops), 255);
    chk("R7", "still no write", int'(wr_en), 0);
    done = 1'b1; step(); done = 1'b0;
    sof = 1'b1; step(); sof = 1'b0;
    chk("R7", "write after done", int'(wr_en), 1);
    chk("R9", "drop stays max", int'(drops), 255);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule